// File: doc/BRIEF.md
# Early-Late-Data Despreading Correlator

This block despreads one baseband signal path (in-phase or quadrature) at the chip rate. It has three correlation lanes that share one signed sample bus. Each lane has its own strobe, so an upstream sampler can feed the Early lane half a chip before the Data lane and the Late lane half a chip after it. On every strobed sample, the lane multiplies the sample by a ±1 code chip. In practice the sample is either kept or negated. The lane then adds the product to a running sum.

The Data lane forms its code from the long PN chip and a Walsh chip, so it recovers one of 64 orthogonal channels. It closes a sum every 64 strobes and slices the sign of that sum into the recovered bit. The Early and Late lanes use the PN chip alone and close a sum every 896 strobes. A synchronization loop outside the block compares their magnitudes.

Each lane keeps two banks. One bank gathers the current period while the other presents the last closed sum, and the two banks swap roles at every close. Each lane runs a small state machine with two states:
- LN_EMPTY: no sum has closed yet. The bit output is forced to 0.
- LN_HOLD: a closed sum is on display.

The lane moves from LN_EMPTY to LN_HOLD on its first close. A synchronous reset returns it to LN_EMPTY from either state.

Top module: `elp_despreader`

## Requirements
- R1: While `rst` is high at a clock edge, every lane clears both banks and its chip index, and enters LN_EMPTY. After that edge all sums read 0, all valid flags are low and `data_bit` is 0.
- R2: The code chip uses the encoding 0 = +1 and 1 = −1. On each strobe the lane adds the sample, sign-extended, when the code chip is 0, and adds its negation when the code chip is 1.
- R3: The Data lane closes after every 64th strobe on `stb_data`. In the cycle after the closing strobe's edge, `data_vld` is high for exactly one cycle and `data_sum` shows the sum of those 64 products.
- R4: The Data lane's code chip for chip index k (0..63 within the bit) is `pn_chip` XOR the parity of (`walsh_sel` AND k). Both values are sampled with each strobe.
- R5: The Early and Late lanes use `pn_chip` alone as the code chip. Each closes after every 896th strobe on its own strobe, with a one-cycle valid pulse in the cycle after the closing edge.
- R6: `data_bit` is 1 when the displayed Data sum is ≥ 0 and 0 when it is negative. `data_bit` is 0 while the Data lane is in LN_EMPTY.
- R7: A displayed sum holds steady between closes while the other bank gathers the next period.
- R8: Sums are 20-bit signed and exact for 896 full-scale samples in either direction (−458752 and +458752).
- R9: The lanes are independent. Strobes on any combination of lanes in the same cycle are each taken into account, and closes of several lanes may coincide.
- R10: A reset in the middle of a period discards the partial sum and restarts that lane's chip index at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-phase clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 10 | Signed input sample shared by the lanes |
| stb_early | input | 1 | Early lane takes `smp_in` this cycle |
| stb_data | input | 1 | Data lane takes `smp_in` this cycle |
| stb_late | input | 1 | Late lane takes `smp_in` this cycle |
| pn_chip | input | 1 | Long PN chip, 0 = +1, 1 = −1 |
| walsh_sel | input | 6 | Walsh channel number for the Data lane |
| early_sum | output | 20 | Last closed Early correlation |
| early_vld | output | 1 | One-cycle pulse when an Early sum closes |
| data_sum | output | 20 | Last closed Data correlation |
| data_vld | output | 1 | One-cycle pulse when a Data sum closes |
| data_bit | output | 1 | Sliced sign of the Data correlation |
| late_sum | output | 20 | Last closed Late correlation |
| late_vld | output | 1 | One-cycle pulse when a Late sum closes |

## Verification
The Data close and the Early/Late closes can land in the same cycle. This happens when all three strobes are held high together: the 896th strobe is also the 14th Data close. The bench provokes this by strobing all three lanes in every cycle from a fresh reset. The scoreboard then expects `data_vld`, `early_vld` and `late_vld` in one cycle, each with its own exact sum. This pattern uses full-scale negative samples with the code chip both 0 and 1, so the same run exercises the overflow bounds.

// File: rtl/elp_pkg.sv
package elp_pkg;
    // lane display state
    typedef enum logic {
        LN_EMPTY = 1'b0,
        LN_HOLD  = 1'b1
    } lane_st_t;

    localparam int SMP_W_DEF    = 10;
    localparam int DATA_LEN_DEF = 64;
    localparam int SYNC_LEN_DEF = 896;
    localparam int WSEL_W_DEF   = 6;
endpackage

// File: rtl/elp_lane.sv
module elp_lane
    import elp_pkg::*;
#(
    parameter int SMP_W     = SMP_W_DEF,
    parameter int LEN       = DATA_LEN_DEF,
    parameter bit USE_WALSH = 1'b0,
    parameter int WSEL_W    = WSEL_W_DEF,
    parameter int ACC_W     = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stb,
    input  logic signed [SMP_W-1:0] smp,
    input  logic                    pn,
    input  logic [WSEL_W-1:0]       wsel,
    output logic signed [ACC_W-1:0] sum,
    output logic                    vld,
    output lane_st_t                st
);
    localparam int CNT_W = $clog2(LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

    logic [CNT_W-1:0]        idx;
    logic                    code;
    logic                    close;
    logic                    sel;
    logic signed [ACC_W-1:0] bank [2];
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] term;
    lane_st_t                st_nx;

    // code chip: PN alone or PN combined with a Walsh chip
    generate
        if (USE_WALSH) begin : g_walsh
            assign code = pn ^ (^(wsel & idx[WSEL_W-1:0]));
        end else begin : g_pn
            logic unused_wsel;
            assign unused_wsel = ^wsel;
            assign code = pn;
        end
    endgenerate

    assign ext   = {{(ACC_W-SMP_W){smp[SMP_W-1]}}, smp};
    assign term  = code ? -ext : ext;
    assign close = stb && (idx == LAST);

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            LN_EMPTY: st_nx = close ? LN_HOLD : LN_EMPTY;
            LN_HOLD:  st_nx = LN_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= LN_EMPTY;
        else     st <= st_nx;
    end

    // banks, index, pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            bank[0] <= '0;
            bank[1] <= '0;
            sel     <= 1'b0;
            idx     <= '0;
            vld     <= 1'b0;
        end else begin
            vld <= close;
            if (stb) begin
                bank[sel] <= bank[sel] + term;
                if (close) begin
                    bank[~sel] <= '0;
                    sel        <= ~sel;
                    idx        <= '0;
                end else begin
                    idx <= idx + CNT_W'(1);
                end
            end
        end
    end

    assign sum = bank[~sel];
endmodule

// File: rtl/elp_despreader.sv
module elp_despreader
    import elp_pkg::*;
#(
    parameter int SMP_W    = SMP_W_DEF,
    parameter int DATA_LEN = DATA_LEN_DEF,
    parameter int SYNC_LEN = SYNC_LEN_DEF,
    parameter int WSEL_W   = WSEL_W_DEF,
    parameter int ACC_W    = SMP_W + $clog2(SYNC_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic                    stb_early,
    input  logic                    stb_data,
    input  logic                    stb_late,
    input  logic                    pn_chip,
    input  logic [WSEL_W-1:0]       walsh_sel,
    output logic signed [ACC_W-1:0] early_sum,
    output logic                    early_vld,
    output logic signed [ACC_W-1:0] data_sum,
    output logic                    data_vld,
    output logic                    data_bit,
    output logic signed [ACC_W-1:0] late_sum,
    output logic                    late_vld
);
    lane_st_t st_e, st_d, st_l;

    elp_lane #(.SMP_W(SMP_W), .LEN(SYNC_LEN), .USE_WALSH(1'b0),
               .WSEL_W(WSEL_W), .ACC_W(ACC_W)) u_early (
        .clk(clk), .rst(rst), .stb(stb_early), .smp(smp_in), .pn(pn_chip),
        .wsel(walsh_sel), .sum(early_sum), .vld(early_vld), .st(st_e));

    elp_lane #(.SMP_W(SMP_W), .LEN(DATA_LEN), .USE_WALSH(1'b1),
               .WSEL_W(WSEL_W), .ACC_W(ACC_W)) u_data (
        .clk(clk), .rst(rst), .stb(stb_data), .smp(smp_in), .pn(pn_chip),
        .wsel(walsh_sel), .sum(data_sum), .vld(data_vld), .st(st_d));

    elp_lane #(.SMP_W(SMP_W), .LEN(SYNC_LEN), .USE_WALSH(1'b0),
               .WSEL_W(WSEL_W), .ACC_W(ACC_W)) u_late (
        .clk(clk), .rst(rst), .stb(stb_late), .smp(smp_in), .pn(pn_chip),
        .wsel(walsh_sel), .sum(late_sum), .vld(late_vld), .st(st_l));

    logic unused_st;
    assign unused_st = (st_e == LN_HOLD) ^ (st_l == LN_HOLD);

    // slicer: sign of the displayed data sum, quiet until the first close
    always_comb begin
        unique case (st_d)
            LN_EMPTY: data_bit = 1'b0;
            LN_HOLD:  data_bit = ~data_sum[ACC_W-1];
        endcase
    end
endmodule

// File: rtl/elp_despreader_chk.sv
module elp_despreader_chk #(
    parameter int SMP_W    = 10,
    parameter int DATA_LEN = 64,
    parameter int SYNC_LEN = 896,
    parameter int WSEL_W   = 6,
    parameter int ACC_W    = 20
) (
    input logic                    clk,
    input logic                    rst,
    input logic signed [SMP_W-1:0] smp_in,
    input logic                    stb_early,
    input logic                    stb_data,
    input logic                    stb_late,
    input logic                    pn_chip,
    input logic [WSEL_W-1:0]       walsh_sel,
    input logic signed [ACC_W-1:0] early_sum,
    input logic                    early_vld,
    input logic signed [ACC_W-1:0] data_sum,
    input logic                    data_vld,
    input logic                    data_bit,
    input logic signed [ACC_W-1:0] late_sum,
    input logic                    late_vld
);
    logic [15:0] dcnt, ecnt, lcnt;
    logic unused_in;
    assign unused_in = ^{smp_in, pn_chip, walsh_sel};

    // strobes seen since the last close of each lane
    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt <= '0;
            ecnt <= '0;
            lcnt <= '0;
        end else begin
            dcnt <= (data_vld  ? 16'd0 : dcnt) + 16'(stb_data);
            ecnt <= (early_vld ? 16'd0 : ecnt) + 16'(stb_early);
            lcnt <= (late_vld  ? 16'd0 : lcnt) + 16'(stb_late);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (data_sum == '0 && early_sum == '0 && late_sum == '0 &&
                 !data_vld && !early_vld && !late_vld && !data_bit));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        data_vld |=> !data_vld);

    assert_data_period_R3: assert property (@(posedge clk) disable iff (rst)
        data_vld |-> dcnt == 16'(DATA_LEN));

    assert_early_period_R5: assert property (@(posedge clk) disable iff (rst)
        early_vld |-> ecnt == 16'(SYNC_LEN));

    assert_late_period_R5: assert property (@(posedge clk) disable iff (rst)
        late_vld |-> lcnt == 16'(SYNC_LEN));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !data_vld |-> $stable(data_sum));

    assert_early_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !early_vld |-> $stable(early_sum));
endmodule

bind elp_despreader elp_despreader_chk #(
    .SMP_W(SMP_W), .DATA_LEN(DATA_LEN), .SYNC_LEN(SYNC_LEN),
    .WSEL_W(WSEL_W), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst(rst), .smp_in(smp_in), .stb_early(stb_early),
    .stb_data(stb_data), .stb_late(stb_late), .pn_chip(pn_chip),
    .walsh_sel(walsh_sel), .early_sum(early_sum), .early_vld(early_vld),
    .data_sum(data_sum), .data_vld(data_vld), .data_bit(data_bit),
    .late_sum(late_sum), .late_vld(late_vld)
);

// File: tb/sim_elp_despreader.sv
module sim_elp_despreader;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic signed [9:0] smp_in = '0;
    logic              stb_early = 1'b0, stb_data = 1'b0, stb_late = 1'b0;
    logic              pn_chip = 1'b0;
    logic [5:0]        walsh_sel = '0;
    logic signed [19:0] early_sum, data_sum, late_sum;
    logic              early_vld, data_vld, late_vld, data_bit;

    always #2 clk = ~clk;

    elp_despreader u0 (
        .clk(clk), .rst(rst), .smp_in(smp_in), .stb_early(stb_early),
        .stb_data(stb_data), .stb_late(stb_late), .pn_chip(pn_chip),
        .walsh_sel(walsh_sel), .early_sum(early_sum), .early_vld(early_vld),
        .data_sum(data_sum), .data_vld(data_vld), .data_bit(data_bit),
        .late_sum(late_sum), .late_vld(late_vld));

    int checks = 0, errors = 0;
    int q_d[$], q_e[$], q_l[$];
    int acc_d, acc_e, acc_l, n_d, n_e, n_l;
    int last_d, last_e, last_l;
    bit have_d;
    bit done = 1'b0;
    string tag = "R1";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        acc_d = 0; acc_e = 0; acc_l = 0;
        n_d = 0; n_e = 0; n_l = 0;
        last_d = 0; last_e = 0; last_l = 0;
        have_d = 1'b0;
        q_d.delete(); q_e.delete(); q_l.delete();
    endtask

    // driver: one cycle of stimulus, expected results pushed as periods close
    task automatic step(input bit se, input bit sd, input bit sl,
                        input int s, input bit pn, input logic [5:0] w);
        bit cd;
        @(negedge clk);
        stb_early = se; stb_data = sd; stb_late = sl;
        smp_in = 10'(s); pn_chip = pn; walsh_sel = w;
        if (sd) begin
            cd = pn ^ (^(w & 6'(n_d)));      // R4 code chip
            acc_d += cd ? -s : s;            // R2 sign modulation
            n_d++;
            if (n_d == 64) begin q_d.push_back(acc_d); acc_d = 0; n_d = 0; end
        end
        if (se) begin
            acc_e += pn ? -s : s;
            n_e++;
            if (n_e == 896) begin q_e.push_back(acc_e); acc_e = 0; n_e = 0; end
        end
        if (sl) begin
            acc_l += pn ? -s : s;
            n_l++;
            if (n_l == 896) begin q_l.push_back(acc_l); acc_l = 0; n_l = 0; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0, 1'b0, 6'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        stb_early = 1'b0; stb_data = 1'b0; stb_late = 1'b0;
        repeat (4) @(negedge clk);
        model_clear();
        rst = 1'b0;
        // R1 reset state, R6 quiet slicer
        chk(data_sum == 0 && early_sum == 0 && late_sum == 0, "R1 sums after reset",
            int'(data_sum), 0);
        chk(!data_vld && !early_vld && !late_vld, "R1 valids after reset",
            int'({early_vld, data_vld, late_vld}), 0);
        chk(data_bit == 1'b0, "R6 bit before first close", int'(data_bit), 0);
    endtask

    // monitor: pops expected sums on each valid, checks holding otherwise
    always begin
        @(posedge clk);
        #1;
        if (!rst && !done) begin
            if (data_vld) begin
                if (q_d.size() == 0) chk(1'b0, {"R3 unexpected data close ", tag}, int'(data_sum), 0);
                else begin
                    last_d = q_d.pop_front();
                    have_d = 1'b1;
                    chk(int'(data_sum) == last_d, {"R3 data sum ", tag}, int'(data_sum), last_d);
                end
            end else
                chk(int'(data_sum) == last_d, {"R7 data hold ", tag}, int'(data_sum), last_d);
            chk(data_bit == (have_d ? (last_d >= 0) : 1'b0), {"R6 slicer ", tag},
                int'(data_bit), int'(have_d ? (last_d >= 0) : 1'b0));
            if (early_vld) begin
                if (q_e.size() == 0) chk(1'b0, {"R5 unexpected early close ", tag}, int'(early_sum), 0);
                else begin
                    last_e = q_e.pop_front();
                    chk(int'(early_sum) == last_e, {"R5 early sum ", tag}, int'(early_sum), last_e);
                end
            end else
                chk(int'(early_sum) == last_e, {"R7 early hold ", tag}, int'(early_sum), last_e);
            if (late_vld) begin
                if (q_l.size() == 0) chk(1'b0, {"R5 unexpected late close ", tag}, int'(late_sum), 0);
                else begin
                    last_l = q_l.pop_front();
                    chk(int'(late_sum) == last_l, {"R5 late sum ", tag}, int'(late_sum), last_l);
                end
            end else
                chk(int'(late_sum) == last_l, {"R7 late hold ", tag}, int'(late_sum), last_l);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();

        // R2 R4: staggered lanes, one strobe per cycle, random samples and PN
        tag = "R2 R4 staggered";
        for (int i = 0; i < 3 * 896 * 2; i++)
            step(i % 3 == 0, i % 3 == 1, i % 3 == 2,
                 int'($urandom_range(0, 1023)) - 512, 1'($urandom_range(0, 1)), 6'd37);
        idle(3);

        // R10: reset in the middle of a data period
        tag = "R10 partial";
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, 300, 1'b0, 6'd0);
        do_reset();

        // R8 R9: all lanes strobed every cycle, full-scale samples
        tag = "R8 R9 negative";
        for (int i = 0; i < 896; i++) step(1'b1, 1'b1, 1'b1, -512, 1'b0, 6'd0);
        tag = "R8 R9 negated";
        for (int i = 0; i < 896; i++) step(1'b1, 1'b1, 1'b1, -512, 1'b1, 6'd0);
        idle(3);

        // R4: Walsh channel changes each bit, samples shaped to the selected code
        tag = "R4 walsh";
        for (int b = 0; b < 8; b++)
            for (int k = 0; k < 64; k++) begin
                automatic logic [5:0] w = 6'(b * 11 + 5);
                automatic int s = (^(w & 6'(k))) ? -200 : 200;
                if (b % 2 == 1) s = -s + int'($urandom_range(0, 40)) - 20;
                step(1'b0, 1'b1, 1'b0, s, 1'b0, w);
            end
        idle(4);

        chk(q_d.size() == 0 && q_e.size() == 0 && q_l.size() == 0,
            "R3 R5 pending results", q_d.size() + q_e.size() + q_l.size(), 0);
        finish_run();
    end
endmodule